// File: doc/BRIEF.md
# Replicated Multi-Core Register Memory

This block is the shared data store of an N-core processor in which every core has one write port and two read ports, all usable on every clock cycle. No core ever waits and nothing arbitrates. All ports are presented side by side at the block's edge.

The block gets these ports by replication. There are 2·N full copies of the logical space, one for each read port. Each copy is cut into N banks, one per writing core. A write from core k goes to bank k of every copy on the same edge.

The logical space is divided evenly into N regions, and core k owns region k. The compiler places variables so that a core only stores into its own region. The block flags and drops any write that falls outside the writer's region. Reads are synchronous with one cycle of latency.

Top module: `mcrm_mem`

## Requirements
- R1: Read port p (core p/2, read r = p%2, address slice `rd_addr[p*AW +: AW]`, data slice `rd_data[p*DW +: DW]`) accepts an address on every cycle. It returns the cell's content on the following cycle.
- R2: A read of a cell that is written on the same edge returns the value held before that write. A read issued on the next cycle returns the new value.
- R3: A write accepted from any core is visible on all 2·N read ports from the next cycle on.
- R4: Core k owns the addresses whose upper log2(N) bits equal k. A write from core k outside that region leaves every cell unchanged.
- R5: `wr_err[k]` is 1 for exactly the cycle after core k issues a write outside its region, and 0 after every other cycle.
- R6: Writes from all N cores on the same edge, each into its own region, all take effect.
- R7: While reset is asserted, `rd_data` and `wr_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | N | Write strobe, bit k for core k |
| wr_addr | input | N*AW | Write address, slice k for core k |
| wr_data | input | N*DW | Write data, slice k for core k |
| rd_addr | input | 2*N*AW | Read address, slice p for read port p |
| rd_data | output | 2*N*DW | Read data, slice p for read port p |
| wr_err | output | N | Out-of-region write flag, bit k for core k |

## Verification
The bench builds the block with N=2 and a 16-cell space. At that size, every address can be swept from the owning core and from the foreign core. Each cell can also be read while it is being written, on all four read ports at once. A behavioural array model then follows thousands of random concurrent cycles, covering same-edge read/write pairs and dropped writes in every combination of the two cores.

// File: rtl/mcrm_pkg.sv
package mcrm_pkg;

    // Default cell width of the data store.
    localparam int unsigned CELL_BITS = 64;

    // Registered state of one write guard.
    typedef struct packed {
        logic err;
    } guard_st_t;

endpackage

// File: rtl/mcrm_wr_guard.sv
module mcrm_wr_guard
    import mcrm_pkg::*;
#(
    parameter int unsigned N       = 4,
    parameter int unsigned AW      = 8,
    parameter int unsigned CORE_ID = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    output logic                          bank_we,
    output logic [AW-$clog2(N)-1:0]       bank_addr,
    output logic                          wr_err
);
    localparam int unsigned RW = $clog2(N);
    localparam int unsigned LW = AW - RW;

    guard_st_t st_d, st_q;
    logic      in_own;

    always_comb begin
        in_own    = (wr_addr[AW-1:LW] == RW'(CORE_ID));
        bank_we   = wr_en && in_own;
        bank_addr = wr_addr[LW-1:0];
        st_d      = st_q;
        st_d.err  = wr_en && !in_own;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_err = st_q.err;

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> $past(wr_en)); // R5

endmodule

// File: rtl/mcrm_bank.sv
module mcrm_bank #(
    parameter int unsigned DW = 64,
    parameter int unsigned LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [LW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [LW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned WORDS = 1 << LW;

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rd_d = mem[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q;

    AST_WADDR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr)); // R3

endmodule

// File: rtl/mcrm_copy.sv
module mcrm_copy #(
    parameter int unsigned N  = 4,
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N-1:0]                  bank_we,
    input  logic [N*(AW-$clog2(N))-1:0]   bank_waddr,
    input  logic [N*DW-1:0]               bank_wdata,
    input  logic [AW-1:0]                 raddr,
    output logic [DW-1:0]                 rdata
);
    localparam int unsigned RW = $clog2(N);
    localparam int unsigned LW = AW - RW;

    logic [DW-1:0] bank_rd [N];
    logic [RW-1:0] sel_d, sel_q;

    for (genvar b = 0; b < N; b++) begin : g_bank
        mcrm_bank #(.DW(DW), .LW(LW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .waddr (bank_waddr[b*LW +: LW]),
            .wdata (bank_wdata[b*DW +: DW]),
            .raddr (raddr[LW-1:0]),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        sel_d = raddr[AW-1:LW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign rdata = bank_rd[sel_q];

endmodule

// File: rtl/mcrm_mem.sv
module mcrm_mem
    import mcrm_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned DEPTH = 256,
    parameter int unsigned DW    = CELL_BITS,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned NP   = 2 * N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    wr_en,
    input  logic [N*AW-1:0] wr_addr,
    input  logic [N*DW-1:0] wr_data,
    input  logic [NP*AW-1:0] rd_addr,
    output logic [NP*DW-1:0] rd_data,
    output logic [N-1:0]    wr_err
);
    localparam int unsigned RW = $clog2(N);
    localparam int unsigned LW = AW - RW;

    logic [N-1:0]    bank_we;
    logic [N*LW-1:0] bank_waddr;

    for (genvar k = 0; k < N; k++) begin : g_core
        mcrm_wr_guard #(.N(N), .AW(AW), .CORE_ID(k)) u_guard (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en[k]),
            .wr_addr   (wr_addr[k*AW +: AW]),
            .bank_we   (bank_we[k]),
            .bank_addr (bank_waddr[k*LW +: LW]),
            .wr_err    (wr_err[k])
        );

        AST_WRITE_OR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_en[k])) |-> (wr_err[k] != $past(bank_we[k]))); // R4
    end

    for (genvar p = 0; p < NP; p++) begin : g_port
        mcrm_copy #(.N(N), .AW(AW), .DW(DW)) u_copy (
            .clk        (clk),
            .rst_n      (rst_n),
            .bank_we    (bank_we),
            .bank_waddr (bank_waddr),
            .bank_wdata (wr_data),
            .raddr      (rd_addr[p*AW +: AW]),
            .rdata      (rd_data[p*DW +: DW])
        );

        AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2)
             && ($past(rd_addr[p*AW +: AW]) == $past(rd_addr[p*AW +: AW], 2))
             && ($past(bank_we, 2) == '0)
             && !$isunknown(rd_data[p*DW +: DW])
             && !$isunknown($past(rd_data[p*DW +: DW])))
            |-> $stable(rd_data[p*DW +: DW])); // R1
    end

endmodule

// File: tb/mcrm_mem_tb.sv
`timescale 1ns/1ps
module mcrm_mem_tb;
    localparam int N  = 2;
    localparam int D  = 16;
    localparam int AW = 4;
    localparam int DW = 64;
    localparam int NP = 2 * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    wr_en = '0;
    logic [N*AW-1:0] wr_addr = '0;
    logic [N*DW-1:0] wr_data = '0;
    logic [NP*AW-1:0] rd_addr = '0;
    logic [NP*DW-1:0] rd_data;
    logic [N-1:0]    wr_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [D];

    always #2 clk = ~clk;

    mcrm_mem #(.N(N), .DEPTH(D), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return {32'(salt) ^ 32'h5AC3_0000, 32'(a) * 32'h0101_0101 + 32'(salt)};
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: predict, advance the model, clock, compare at the negedge.
    task automatic step(input string rtag);
        logic [DW-1:0] exp_rd [NP];
        logic [N-1:0]  exp_err;
        for (int p = 0; p < NP; p++) exp_rd[p] = model[rd_addr[p*AW +: AW]];
        for (int k = 0; k < N; k++) begin
            int a = int'(wr_addr[k*AW +: AW]);
            exp_err[k] = wr_en[k] && ((a / (D / N)) != k);
            if (wr_en[k] && !exp_err[k]) model[a] = wr_data[k*DW +: DW];
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            if (!$isunknown(exp_rd[p])) chk(rtag, rd_data[p*DW +: DW], exp_rd[p]);
        chk("R5", DW'(wr_err), DW'(exp_err));
    endtask

    task automatic all_read(input int a);
        for (int p = 0; p < NP; p++) rd_addr[p*AW +: AW] = AW'(a);
    endtask

    initial begin
        for (int i = 0; i < D; i++) model[i] = 'x;
        repeat (3) @(negedge clk);
        chk("R7", rd_data[DW-1:0] | rd_data[NP*DW-1:DW], '0);
        chk("R7", DW'(wr_err), '0);
        rst_n = 1'b1;

        // Concurrent fill: each core writes its whole region (R6).
        for (int i = 0; i < D / N; i++) begin
            wr_en = '1;
            for (int k = 0; k < N; k++) begin
                wr_addr[k*AW +: AW] = AW'(k * (D / N) + i);
                wr_data[k*DW +: DW] = pat(k * (D / N) + i, 1);
            end
            step("R6");
        end
        wr_en = '0;

        // Read sweep: every address on every port at staggered offsets (R1).
        for (int a = 0; a < D + 1; a++) begin
            for (int p = 0; p < NP; p++) rd_addr[p*AW +: AW] = AW'((a + p * 5) % D);
            step("R1");
        end

        // Read during write, then read after (R2, R3).
        for (int a = 0; a < D; a++) begin
            wr_en = '0;
            wr_en[a / (D / N)] = 1'b1;
            wr_addr[(a / (D / N))*AW +: AW] = AW'(a);
            wr_data[(a / (D / N))*DW +: DW] = pat(a, 2);
            all_read(a);
            step("R2");
            wr_en = '0;
            step("R3");
        end

        // Foreign writes are dropped and flagged (R4, R5).
        for (int a = 0; a < D; a++) begin
            int k = 1 - a / (D / N);
            wr_en = '0;
            wr_en[k] = 1'b1;
            wr_addr[k*AW +: AW] = AW'(a);
            wr_data[k*DW +: DW] = pat(a, 7);
            all_read(a);
            step("R5");
            wr_en = '0;
            step("R4");
        end

        // Random concurrent traffic against the model (R1).
        for (int c = 0; c < 3000; c++) begin
            wr_en = N'($urandom);
            wr_addr = (N*AW)'($urandom);
            for (int k = 0; k < N; k++)
                wr_data[k*DW +: DW] = {$urandom, $urandom};
            rd_addr = (NP*AW)'($urandom);
            step("R1");
        end
        wr_en = '0;

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule